// File: doc/BRIEF.md
# External interrupt trigger and flag control

This block turns two active-low external interrupt pins into request flags and keeps them in one 8-bit control byte. The same byte holds the two timer run bits and the two timer overflow flags. Each pin has its own trigger-type bit. With the type bit at 1, a falling edge on the pin latches the request flag. With the type bit at 0, the flag simply shows whether the pin is low right now.

Software reads the whole byte. It can write the byte as a whole, or change any single bit by giving a bit index and a value. The interrupt controller returns an acknowledge per source when it services a request, and that acknowledge clears the latched flag. The timers are outside this block. Their overflow events arrive as one-cycle set pulses, and the run bits go back out to them.

Both pins pass through a synchroniser before any decision is made, so they may change at any time relative to the clock.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The control byte reads, from bit 7 down to bit 0, as: timer-1 overflow flag, timer-1 run, timer-0 overflow flag, timer-0 run, external-1 request flag, external-1 type, external-0 request flag, external-0 type.
- R2: After reset the control byte reads 00h, and the request and run outputs are all zero.
- R3: A type bit of 1 selects falling-edge triggering for that pin. A type bit of 0 selects low-level triggering.
- R4: Each pin passes through a two-stage synchroniser. A falling edge is a synchronised 1 followed by a synchronised 0. In edge mode this sets the request flag, and the flag reads 1 after the third rising clock edge that follows the pin falling.
- R5: In level mode the request flag reads as the inverted synchronised pin, two clock edges after the pin changes. Acknowledges and software writes to that flag have no visible effect while in level mode.
- R6: An acknowledge clears a latched edge-mode request flag at the next edge. An acknowledge on a timer source clears that timer's overflow flag at the next edge.
- R7: A software write to an edge-mode request flag or an overflow flag loads the written value. A software write takes precedence over an acknowledge in the same cycle.
- R8: A hardware set of a flag, from a detected falling edge or a timer overflow pulse, wins over a software clear and over an acknowledge in the same cycle.
- R9: The run bits change only through software writes.
- R10: A single-bit write uses the index as the bit position in the byte (0 to 7) and changes only that bit.
- R11: When a byte write and a single-bit write arrive in the same cycle, only the byte write takes effect.
- R12: In edge mode, one falling edge sets the flag once. Holding the pin low, or letting it rise, does not set the flag again after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_ovf_set | input | 2 | One-cycle overflow set pulses from timer 0 (bit 0) and timer 1 (bit 1) |
| ack_ext | input | 2 | Service acknowledge for external source 0 and 1 |
| ack_tmr | input | 2 | Service acknowledge for timer source 0 and 1 |
| wr_byte_en | input | 1 | Whole-byte write strobe |
| wr_byte_data | input | 8 | Whole-byte write data |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_idx | input | 3 | Bit position for a single-bit write |
| wr_bit_val | input | 1 | Value for a single-bit write |
| ctrl_rd | output | 8 | Control byte read value |
| run_out | output | 2 | Timer run bits (bit 0 timer 0, bit 1 timer 1) |
| ext_req | output | 2 | External request flags to the interrupt controller |
| tmr_req | output | 2 | Timer overflow flags to the interrupt controller |

## Verification
The pins are driven in three patterns. A low pulse that is then held low in edge mode shows that a flag is latched once per edge and does not set again. The same held-low pattern in level mode shows that the flag follows the pin and ignores clears. A release back high shows that rising edges set nothing. Reads taken one edge early and one edge late pin down the synchroniser latency in both modes. Cycles where a hardware set meets a software clear or an acknowledge separate the three orders of precedence. Single-bit writes at different indices, and a write that collides with a byte write, show which bits a write may touch.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int CTRL_W  = 8;
  localparam int NUM_SRC = 2;
  localparam int IDX_W   = $clog2(CTRL_W);

  // Bit positions inside the control byte for source n
  function automatic int pos_type(input int n);
    return 2 * n;
  endfunction

  function automatic int pos_ext_flag(input int n);
    return 2 * n + 1;
  endfunction

  function automatic int pos_run(input int n);
    return 4 + 2 * n;
  endfunction

  function automatic int pos_ovf_flag(input int n);
    return 5 + 2 * n;
  endfunction

  // Which bits a write cycle touches; byte writes take precedence
  function automatic logic [CTRL_W-1:0] wr_mask(input logic byte_en,
                                                input logic bit_en,
                                                input logic [IDX_W-1:0] idx);
    logic [CTRL_W-1:0] m;
    m = '0;
    if (byte_en)     m = '1;
    else if (bit_en) m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [CTRL_W-1:0] wr_data(input logic byte_en,
                                                input logic [CTRL_W-1:0] byte_data,
                                                input logic bit_val);
    return byte_en ? byte_data : {CTRL_W{bit_val}};
  endfunction

  // Synchronised sample went from 1 to 0
  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // Flag update order: hardware set, software write, acknowledge, hold
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic ack, input logic sw_we,
                                     input logic sw_val);
    if (hw_set)     return 1'b1;
    else if (sw_we) return sw_val;
    else if (ack)   return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    // Pins are active low: reset to the idle (high) level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q[0] <= d[i];
        for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
    end

    assign q[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ctrl_wr_decode.sv
module ctrl_wr_decode
  import ext_irq_pkg::*;
(
  input  logic              byte_en,
  input  logic [CTRL_W-1:0] byte_data,
  input  logic              bit_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_val,
  output logic [CTRL_W-1:0] we_mask,
  output logic [CTRL_W-1:0] wdata
);

  always_comb begin
    we_mask = wr_mask(byte_en, bit_en, bit_idx);
    wdata   = wr_data(byte_en, byte_data, bit_val);
  end

endmodule

// File: rtl/irq_channel.sv
module irq_channel
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,    // synchronised pin, active low
  input  logic edge_mode,  // 1: falling edge, 0: low level
  input  logic ack,
  input  logic sw_we,
  input  logic sw_val,
  output logic flag_rd,
  output logic fall_evt
);

  logic prev_q;
  logic latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_in;
  end

  assign fall_evt = is_fall(prev_q, sync_in);

  // Latched flag is only meaningful in edge mode; held clear otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latch_q <= 1'b0;
    else if (!edge_mode) latch_q <= 1'b0;
    else                 latch_q <= flag_next(latch_q, fall_evt, ack, sw_we, sw_val);
  end

  assign flag_rd = edge_mode ? latch_q : ~sync_in;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_pin_n,
  input  logic [NUM_SRC-1:0]  tmr_ovf_set,
  input  logic [NUM_SRC-1:0]  ack_ext,
  input  logic [NUM_SRC-1:0]  ack_tmr,
  input  logic                wr_byte_en,
  input  logic [CTRL_W-1:0]   wr_byte_data,
  input  logic                wr_bit_en,
  input  logic [IDX_W-1:0]    wr_bit_idx,
  input  logic                wr_bit_val,
  output logic [CTRL_W-1:0]   ctrl_rd,
  output logic [NUM_SRC-1:0]  run_out,
  output logic [NUM_SRC-1:0]  ext_req,
  output logic [NUM_SRC-1:0]  tmr_req
);

  // Named internal events, brought out for the checker
  logic [NUM_SRC-1:0] sync_lvl;
  logic [NUM_SRC-1:0] fall_evt;
  logic [NUM_SRC-1:0] edge_mode;

  logic [CTRL_W-1:0]  we_mask;
  logic [CTRL_W-1:0]  wdata;

  irq_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_pin_n),
    .q     (sync_lvl)
  );

  ctrl_wr_decode u_wdec (
    .byte_en   (wr_byte_en),
    .byte_data (wr_byte_data),
    .bit_en    (wr_bit_en),
    .bit_idx   (wr_bit_idx),
    .bit_val   (wr_bit_val),
    .we_mask   (we_mask),
    .wdata     (wdata)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int P_TYPE = pos_type(n);
    localparam int P_EXT  = pos_ext_flag(n);
    localparam int P_RUN  = pos_run(n);
    localparam int P_OVF  = pos_ovf_flag(n);

    logic type_q;
    logic run_q;
    logic ovf_q;

    // Trigger type: software only
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                type_q <= 1'b0;
      else if (we_mask[P_TYPE])  type_q <= wdata[P_TYPE];
    end

    // Timer run: software only
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_q <= 1'b0;
      else if (we_mask[P_RUN])  run_q <= wdata[P_RUN];
    end

    // Timer overflow flag: set pulse, software write, acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= flag_next(ovf_q, tmr_ovf_set[n], ack_tmr[n],
                                     we_mask[P_OVF], wdata[P_OVF]);
    end

    irq_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (sync_lvl[n]),
      .edge_mode (type_q),
      .ack       (ack_ext[n]),
      .sw_we     (we_mask[P_EXT]),
      .sw_val    (wdata[P_EXT]),
      .flag_rd   (ext_req[n]),
      .fall_evt  (fall_evt[n])
    );

    assign edge_mode[n] = type_q;
    assign run_out[n]   = run_q;
    assign tmr_req[n]   = ovf_q;
  end

  always_comb begin
    ctrl_rd = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      ctrl_rd[pos_type(n)]     = edge_mode[n];
      ctrl_rd[pos_ext_flag(n)] = ext_req[n];
      ctrl_rd[pos_run(n)]      = run_out[n];
      ctrl_rd[pos_ovf_flag(n)] = tmr_req[n];
    end
  end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] tmr_ovf_set,
  input logic [NUM_SRC-1:0] ack_ext,
  input logic [NUM_SRC-1:0] ack_tmr,
  input logic               wr_byte_en,
  input logic               wr_bit_en,
  input logic [IDX_W-1:0]   wr_bit_idx,
  input logic [CTRL_W-1:0]  ctrl_rd,
  input logic [NUM_SRC-1:0] ext_req,
  input logic [NUM_SRC-1:0] sync_lvl,
  input logic [NUM_SRC-1:0] fall_evt,
  input logic [NUM_SRC-1:0] edge_mode
);

  logic any_wr;
  assign any_wr = wr_byte_en | wr_bit_en;

  assert_reset_clear_R2: assert property (@(posedge clk)
    !rst_n |=> (ctrl_rd == '0));

  assert_run_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> ($stable(ctrl_rd[pos_run(0)]) && $stable(ctrl_rd[pos_run(1)])));

  assert_bit_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit_en && !wr_byte_en && wr_bit_idx != IDX_W'(pos_run(1)))
      |=> $stable(ctrl_rd[pos_run(1)]));

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && fall_evt[n] && !any_wr) |=> ext_req[n]);

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode[n] |-> (ext_req[n] == !sync_lvl[n]));

    assert_ext_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && ack_ext[n] && !fall_evt[n] && !any_wr) |=> !ext_req[n]);

    assert_tmr_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tmr[n] && !tmr_ovf_set[n] && !any_wr) |=> !ctrl_rd[pos_ovf_flag(n)]);

    assert_tmr_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_set[n] |=> ctrl_rd[pos_ovf_flag(n)]);
  end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tmr_ovf_set (tmr_ovf_set),
  .ack_ext     (ack_ext),
  .ack_tmr     (ack_tmr),
  .wr_byte_en  (wr_byte_en),
  .wr_bit_en   (wr_bit_en),
  .wr_bit_idx  (wr_bit_idx),
  .ctrl_rd     (ctrl_rd),
  .ext_req     (ext_req),
  .sync_lvl    (sync_lvl),
  .fall_evt    (fall_evt),
  .edge_mode   (edge_mode)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] irq_pin_n = 2'b11;
  logic [1:0] tmr_ovf_set = '0;
  logic [1:0] ack_ext = '0;
  logic [1:0] ack_tmr = '0;
  logic       wr_byte_en = 1'b0;
  logic [7:0] wr_byte_data = '0;
  logic       wr_bit_en = 1'b0;
  logic [2:0] wr_bit_idx = '0;
  logic       wr_bit_val = 1'b0;
  logic [7:0] ctrl_rd;
  logic [1:0] run_out;
  logic [1:0] ext_req;
  logic [1:0] tmr_req;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ext_irq_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_pin_n    (irq_pin_n),
    .tmr_ovf_set  (tmr_ovf_set),
    .ack_ext      (ack_ext),
    .ack_tmr      (ack_tmr),
    .wr_byte_en   (wr_byte_en),
    .wr_byte_data (wr_byte_data),
    .wr_bit_en    (wr_bit_en),
    .wr_bit_idx   (wr_bit_idx),
    .wr_bit_val   (wr_bit_val),
    .ctrl_rd      (ctrl_rd),
    .run_out      (run_out),
    .ext_req      (ext_req),
    .tmr_req      (tmr_req)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_byte_en = 1'b1; wr_byte_data = d;
    step(1);
    wr_byte_en = 1'b0;
  endtask

  task automatic wr_bit(input int idx, input logic v);
    wr_bit_en = 1'b1; wr_bit_idx = 3'(idx); wr_bit_val = v;
    step(1);
    wr_bit_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 ctrl after reset", ctrl_rd, 8'h00);
    chk("R2 outputs after reset", {run_out, ext_req, tmr_req}, 8'h00);
  endtask

  task automatic t_byte_rw;
    wr_byte(8'h50);
    chk("R1 run bits at 6 and 4", ctrl_rd, 8'h50);
    chk("R1 run_out", {6'b0, run_out}, 8'h03);
    step(4);
    chk("R9 run bits hold", ctrl_rd, 8'h50);
    wr_byte(8'hA0);
    chk("R7 overflow flags written", ctrl_rd, 8'hA0);
    chk("R1 tmr_req", {6'b0, tmr_req}, 8'h03);
    wr_byte(8'h00);
    chk("R7 overflow flags cleared", ctrl_rd, 8'h00);
  endtask

  task automatic t_level;
    irq_pin_n[1] = 1'b0;
    step(1);
    chk("R5 level latency early", {7'b0, ctrl_rd[3]}, 8'h00);
    step(1);
    chk("R3 R5 level flag follows pin", ctrl_rd, 8'h08);
    ack_ext[1] = 1'b1;
    step(1);
    ack_ext[1] = 1'b0;
    chk("R5 ack ignored in level mode", {7'b0, ext_req[1]}, 8'h01);
    wr_bit(3, 1'b0);
    chk("R5 sw clear ignored in level mode", ctrl_rd, 8'h08);
    irq_pin_n[1] = 1'b1;
    step(2);
    chk("R5 level flag drops with pin", ctrl_rd, 8'h00);
    wr_byte(8'h08);
    chk("R5 sw set ignored in level mode", ctrl_rd, 8'h00);
  endtask

  task automatic t_edge;
    wr_bit(0, 1'b1);
    chk("R3 type bit edge", ctrl_rd, 8'h01);
    irq_pin_n[0] = 1'b0;
    step(2);
    chk("R4 edge latency early", {7'b0, ctrl_rd[1]}, 8'h00);
    step(1);
    chk("R4 falling edge sets flag", ctrl_rd, 8'h03);
    step(4);
    ack_ext[0] = 1'b1;
    step(1);
    ack_ext[0] = 1'b0;
    chk("R6 ack clears edge flag", ctrl_rd, 8'h01);
    step(4);
    chk("R12 held low no reset", ctrl_rd, 8'h01);
    irq_pin_n[0] = 1'b1;
    step(4);
    chk("R12 rising edge no set", ctrl_rd, 8'h01);
    wr_bit(1, 1'b1);
    chk("R7 sw set edge flag", ctrl_rd, 8'h03);
    ack_ext[0] = 1'b1;
    wr_bit(1, 1'b1);
    ack_ext[0] = 1'b0;
    chk("R7 sw write beats ack", ctrl_rd, 8'h03);
    wr_bit(1, 1'b0);
    chk("R7 sw clear edge flag", ctrl_rd, 8'h01);
  endtask

  task automatic t_priority;
    irq_pin_n[0] = 1'b0;
    step(2);
    wr_bit(1, 1'b0);
    chk("R8 edge set beats sw clear", ctrl_rd, 8'h03);
    irq_pin_n[0] = 1'b1;
    ack_ext[0] = 1'b1;
    step(1);
    ack_ext[0] = 1'b0;
    step(3);
    wr_byte(8'h00);
    tmr_ovf_set[0] = 1'b1; ack_tmr[0] = 1'b1;
    wr_bit(5, 1'b0);
    tmr_ovf_set[0] = 1'b0; ack_tmr[0] = 1'b0;
    chk("R8 overflow set beats clear and ack", ctrl_rd, 8'h20);
    ack_tmr[0] = 1'b1;
    step(1);
    ack_tmr[0] = 1'b0;
    chk("R6 timer ack clears", ctrl_rd, 8'h00);
    tmr_ovf_set[1] = 1'b1;
    step(1);
    tmr_ovf_set[1] = 1'b0;
    chk("R8 timer 1 overflow set", {6'b0, tmr_req}, 8'h02);
    wr_byte(8'h00);
  endtask

  task automatic t_bit_write;
    wr_byte(8'h50);
    wr_bit(4, 1'b0);
    chk("R10 clear bit 4 only", ctrl_rd, 8'h40);
    wr_bit(2, 1'b1);
    chk("R10 set bit 2 only", ctrl_rd, 8'h44);
    wr_bit(6, 1'b0);
    chk("R10 clear bit 6 only", ctrl_rd, 8'h04);
    wr_byte(8'h00);
  endtask

  task automatic t_collide;
    wr_bit_en = 1'b1; wr_bit_idx = 3'd6; wr_bit_val = 1'b1;
    wr_byte(8'h10);
    wr_bit_en = 1'b0;
    chk("R11 byte write wins", ctrl_rd, 8'h10);
    wr_byte(8'h00);
    chk("R11 cleanup", ctrl_rd, 8'h00);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_byte_rw();
    t_level();
    t_edge();
    t_priority();
    t_bit_write();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule